// File: doc/BRIEF.md
# Burst Beat Address and Lane Generator

This block turns one burst descriptor into the sequence of beats a wide memory-mapped data bus carries. A descriptor gives a transaction ID, a start byte address, a beat count, a beat size and a burst kind. For every beat the block presents three things: the address rounded down to the bus word, a byte write strobe that marks the bytes the beat owns, and the beat's data moved from a narrow input onto the matching byte lanes of the wide bus. It covers fixed, incrementing and wrapping bursts. In a wrapping burst the byte lane runs around inside the wrap window.

A producer hands over a descriptor with a valid/ready pair. The generator takes a descriptor only while it is idle. Beats then leave on a valid/ready output with a last flag. The beat data source holds its value on `in_data` and moves on to the next value whenever `in_take` pulses. A descriptor that cannot be carried out raises a one-cycle error pulse and produces no beats.

Top module: `axi_beat_gen`

## Requirements
- R1: After reset `out_valid` is 0, `desc_ready` is 1 and `desc_err` is 0.
- R2: `out_addr` is the byte address of the current beat with its low log2(DATA_W/8) bits cleared. With a 128-bit bus, a start of 0x106 gives 0x100.
- R3: A fixed burst (burst code 0) repeats the same `out_addr` and `out_strb` on every beat. A start of 0x106 with 1-byte beats gives strobe 0x0040 on all beats.
- R4: Bytes 0 to 2^size−1 of `in_data` appear on the bus starting at the lane given by the beat address aligned down to the beat size. All other bytes of `out_data` are zero. A 1-byte beat at offset 6 lands in bits 55:48.
- R5: An incrementing burst (burst code 1) moves on by 2^size bytes per beat. When it runs past the end of a bus word, `out_addr` rises by DATA_W/8 and the lane restarts at 0. From 0x104 with 4-byte beats the strobes are 0x00F0, 0x0F00, 0xF000, 0x000F and the addresses are 0x100, 0x100, 0x100, 0x110.
- R6: When an incrementing burst starts at an address that is not aligned to the beat size, the first strobe covers only the bytes from the start byte up to the next size boundary. Every later beat is aligned to the size. From 0x103 with 4-byte beats the strobes are 0x0008 and then 0x00F0.
- R7: A wrapping burst (burst code 2) stays inside the window of 2^size×(LEN+1) bytes that contains the start address. When it reaches the top of the window it continues from the window base.
- R8: A burst carries exactly LEN+1 beats (LEN being the 4-bit `desc_len`). `out_last` is high on the final beat only, and every beat carries the descriptor's ID.
- R9: While `out_valid` is high and `out_ready` is low, the beat holds its address, strobe, last flag and ID. `in_take` pulses exactly once for each beat that is taken.
- R10: The block rejects a descriptor in any of these cases: its beat size (`desc_size` = log2 of the byte count) exceeds the beat input width, its burst code is 3, or it is a wrapping burst whose LEN is not 1, 3, 7 or 15, or whose start address is not aligned to the beat size. A rejected descriptor raises `desc_err` for one cycle and no beat is issued.
- R11: `desc_ready` is low while a burst is in progress. A descriptor offered during that time is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Generator idle, descriptor can be taken |
| desc_id | input | ID_W | Transaction ID |
| desc_addr | input | ADDR_W | Start byte address |
| desc_len | input | 4 | Beats minus one |
| desc_size | input | 3 | log2 of bytes per beat |
| desc_burst | input | 2 | 0 fixed, 1 incrementing, 2 wrapping |
| desc_err | output | 1 | One-cycle pulse on a rejected descriptor |
| in_data | input | IN_W | Narrow data of the current beat |
| in_take | output | 1 | Current beat data consumed |
| out_valid | output | 1 | Beat present |
| out_ready | input | 1 | Beat taken by the bus |
| out_id | output | ID_W | Transaction ID of the beat |
| out_addr | output | ADDR_W | Bus-word aligned beat address |
| out_strb | output | DATA_W/8 | Byte write strobe |
| out_data | output | DATA_W | Lane-steered beat data |
| out_last | output | 1 | Final beat of the burst |

## Verification
The assertions check the cycle-level rules on every cycle: a stalled beat holds steady, nothing follows a final beat, a fixed burst keeps its address and strobe from one beat to the next, a live beat always has a strobe, an error pulse never comes together with a beat, and a burst only starts after a descriptor was offered. The exact strobe and address sequences can only be shown by the bench's directed scenarios. These are lane wrap-around inside a window, the bus-word crossing of an incrementing burst, the partial first strobe, the data placement and the rejection cases, and each scenario compares every beat against values worked out from the requirements.

// File: rtl/beatgen_pkg.sv
package beatgen_pkg;

    typedef enum logic [1:0] {
        BK_FIXED = 2'd0,
        BK_INCR  = 2'd1,
        BK_WRAP  = 2'd2,
        BK_RSVD  = 2'd3
    } burst_kind_e;

    typedef struct packed {
        burst_kind_e kind;
        logic [2:0]  size;
        logic [3:0]  len;
    } beat_ctl_t;

    function automatic logic [7:0] bytes_of(input logic [2:0] size);
        return 8'd1 << size;
    endfunction

    function automatic logic wrap_len_ok(input logic [3:0] len);
        return (len == 4'd1) || (len == 4'd3) || (len == 4'd7) || (len == 4'd15);
    endfunction

endpackage

// File: rtl/beatgen_desc_check.sv
module beatgen_desc_check
    import beatgen_pkg::*;
#(
    parameter int DATA_W = 128,
    parameter int IN_W   = 32
) (
    input  beat_ctl_t  ctl,
    input  logic [6:0] addr_lo,
    output logic       ok
);
    localparam int BUS_LOG = $clog2(DATA_W / 8);
    localparam int IN_LOG  = $clog2(IN_W / 8);
    localparam int MAX_LOG = (IN_LOG < BUS_LOG) ? IN_LOG : BUS_LOG;

    logic size_ok;
    logic align_ok;

    always_comb begin
        size_ok  = (int'(ctl.size) <= MAX_LOG);
        align_ok = (({1'b0, addr_lo} & (bytes_of(ctl.size) - 8'd1)) == 8'd0);
        ok       = size_ok && (ctl.kind != BK_RSVD) &&
                   ((ctl.kind != BK_WRAP) || (wrap_len_ok(ctl.len) && align_ok));
    end
endmodule

// File: rtl/beatgen_addr_step.sv
module beatgen_addr_step
    import beatgen_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] cur,
    input  burst_kind_e       kind,
    input  logic [2:0]        size,
    input  logic [ADDR_W-1:0] wmask,
    output logic [ADDR_W-1:0] nxt
);
    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] based;
    logic [ADDR_W-1:0] sum;

    always_comb begin
        step  = ADDR_W'(bytes_of(size));
        based = cur & ~(step - ADDR_W'(1));
        sum   = based + step;
        unique case (kind)
            BK_INCR: nxt = sum;
            BK_WRAP: nxt = (cur & ~wmask) | (sum & wmask);
            default: nxt = cur;
        endcase
    end
endmodule

// File: rtl/beatgen_lane_steer.sv
module beatgen_lane_steer #(
    parameter int DATA_W = 128,
    parameter int IN_W   = 32,
    localparam int BUS_B = DATA_W / 8,
    localparam int IN_B  = IN_W / 8,
    localparam int OFF_W = $clog2(BUS_B)
) (
    input  logic [OFF_W-1:0]  lane_off,
    input  logic [2:0]        size,
    input  logic [IN_W-1:0]   in_data,
    output logic [BUS_B-1:0]  strb,
    output logic [DATA_W-1:0] data
);
    logic [IN_W-1:0] in_masked;

    for (genvar k = 0; k < IN_B; k++) begin : g_keep
        assign in_masked[k*8 +: 8] = (32'(k) < (32'd1 << size)) ? in_data[k*8 +: 8] : 8'h00;
    end

    int nb;
    int ln;
    int al;

    always_comb begin
        nb = 1 << size;
        ln = int'(lane_off);
        al = ln & ~(nb - 1);
        for (int b = 0; b < BUS_B; b++) begin
            strb[b] = (b >= ln) && (b < al + nb);
        end
        data = DATA_W'(in_masked) << (al * 8);
    end
endmodule

// File: rtl/axi_beat_gen.sv
module axi_beat_gen
    import beatgen_pkg::*;
#(
    parameter int ID_W   = 4,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 128,
    parameter int IN_W   = 32,
    localparam int BUS_B = DATA_W / 8,
    localparam int OFF_W = $clog2(BUS_B)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              desc_valid,
    output logic              desc_ready,
    input  logic [ID_W-1:0]   desc_id,
    input  logic [ADDR_W-1:0] desc_addr,
    input  logic [3:0]        desc_len,
    input  logic [2:0]        desc_size,
    input  logic [1:0]        desc_burst,
    output logic              desc_err,
    input  logic [IN_W-1:0]   in_data,
    output logic              in_take,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ID_W-1:0]   out_id,
    output logic [ADDR_W-1:0] out_addr,
    output logic [BUS_B-1:0]  out_strb,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last
);
    beat_ctl_t         new_ctl;
    logic              desc_ok;
    logic              accept;
    logic              fire;
    logic [ADDR_W-1:0] span;

    logic              busy;
    logic              err_q;
    logic [ADDR_W-1:0] cur_addr;
    logic [3:0]        left;
    burst_kind_e       kind_q;
    logic [2:0]        size_q;
    logic [ADDR_W-1:0] wmask_q;
    logic [ID_W-1:0]   id_q;
    logic [ADDR_W-1:0] nxt_addr;

    assign new_ctl = '{kind: burst_kind_e'(desc_burst), size: desc_size, len: desc_len};
    assign span    = ADDR_W'(bytes_of(desc_size)) * (ADDR_W'(desc_len) + ADDR_W'(1));
    assign accept  = desc_valid && !busy;
    assign fire    = busy && out_ready;

    beatgen_desc_check #(.DATA_W(DATA_W), .IN_W(IN_W)) u_check (
        .ctl     (new_ctl),
        .addr_lo (desc_addr[6:0]),
        .ok      (desc_ok)
    );

    beatgen_addr_step #(.ADDR_W(ADDR_W)) u_step (
        .cur   (cur_addr),
        .kind  (kind_q),
        .size  (size_q),
        .wmask (wmask_q),
        .nxt   (nxt_addr)
    );

    beatgen_lane_steer #(.DATA_W(DATA_W), .IN_W(IN_W)) u_steer (
        .lane_off (cur_addr[OFF_W-1:0]),
        .size     (size_q),
        .in_data  (in_data),
        .strb     (out_strb),
        .data     (out_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            err_q    <= 1'b0;
            cur_addr <= '0;
            left     <= '0;
            kind_q   <= BK_FIXED;
            size_q   <= '0;
            wmask_q  <= '0;
            id_q     <= '0;
        end else begin
            err_q <= 1'b0;
            if (accept) begin
                if (desc_ok) begin
                    busy     <= 1'b1;
                    cur_addr <= desc_addr;
                    left     <= desc_len;
                    kind_q   <= new_ctl.kind;
                    size_q   <= desc_size;
                    wmask_q  <= span - ADDR_W'(1);
                    id_q     <= desc_id;
                end else begin
                    err_q <= 1'b1;
                end
            end else if (fire) begin
                if (left == 4'd0) begin
                    busy <= 1'b0;
                end else begin
                    cur_addr <= nxt_addr;
                    left     <= left - 4'd1;
                end
            end
        end
    end

    assign desc_ready = !busy;
    assign desc_err   = err_q;
    assign out_valid  = busy;
    assign in_take    = fire;
    assign out_last   = busy && (left == 4'd0);
    assign out_id     = id_q;
    assign out_addr   = cur_addr & ~ADDR_W'(BUS_B - 1);

    // R9: a stalled beat holds
    a_r9_hold_beat: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_strb)
                                       && $stable(out_last) && $stable(out_id)));

    // R8: nothing follows the final beat
    a_r8_last_ends: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last) |=> !out_valid);

    // R3: fixed burst repeats address and strobe
    a_r3_fixed_same: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && !out_last && kind_q == BK_FIXED)
            |=> ($stable(out_addr) && $stable(out_strb)));

    // R6: every live beat owns at least one byte
    a_r6_strb_live: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_strb != '0));

    // R10: an error pulse never comes with a beat
    a_r10_err_no_beat: assert property (@(posedge clk) disable iff (rst)
        desc_err |-> !out_valid);

    // R11: a burst only starts from an offered descriptor
    a_r11_start_from_desc: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(desc_valid));
endmodule

// File: tb/sim_axi_beat_gen.sv
module sim_axi_beat_gen;
    localparam int ID_W   = 4;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 128;
    localparam int IN_W   = 32;
    localparam int BUS_B  = DATA_W / 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              desc_valid = 1'b0;
    logic              desc_ready;
    logic [ID_W-1:0]   desc_id = '0;
    logic [ADDR_W-1:0] desc_addr = '0;
    logic [3:0]        desc_len = '0;
    logic [2:0]        desc_size = '0;
    logic [1:0]        desc_burst = '0;
    logic              desc_err;
    logic [IN_W-1:0]   in_data = '0;
    logic              in_take;
    logic              out_valid;
    logic              out_ready = 1'b0;
    logic [ID_W-1:0]   out_id;
    logic [ADDR_W-1:0] out_addr;
    logic [BUS_B-1:0]  out_strb;
    logic [DATA_W-1:0] out_data;
    logic              out_last;

    axi_beat_gen #(.ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IN_W(IN_W)) u0 (
        .clk(clk), .rst(rst),
        .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_id(desc_id),
        .desc_addr(desc_addr), .desc_len(desc_len), .desc_size(desc_size),
        .desc_burst(desc_burst), .desc_err(desc_err),
        .in_data(in_data), .in_take(in_take),
        .out_valid(out_valid), .out_ready(out_ready), .out_id(out_id),
        .out_addr(out_addr), .out_strb(out_strb), .out_data(out_data), .out_last(out_last)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int fails  = 0;

    logic [ADDR_W-1:0] g_addr [32];
    logic [BUS_B-1:0]  g_strb [32];
    logic [DATA_W-1:0] g_data [32];
    logic              g_last [32];
    logic [ID_W-1:0]   g_id   [32];
    logic [IN_W-1:0]   vals   [32];
    int g_n;
    int takes;

    task automatic check_eq(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [ID_W-1:0] id, input logic [ADDR_W-1:0] addr,
                        input logic [3:0] len, input logic [2:0] size, input logic [1:0] kind);
        @(negedge clk);
        desc_id = id; desc_addr = addr; desc_len = len; desc_size = size; desc_burst = kind;
        desc_valid = 1'b1;
        @(negedge clk);
        desc_valid = 1'b0;
    endtask

    task automatic collect(input int n, input bit stall);
        int cyc = 0;
        g_n = 0;
        takes = 0;
        while (g_n < n && cyc < 200) begin
            out_ready = stall ? (cyc % 2 == 1) : 1'b1;
            in_data = vals[g_n];
            #1;
            if (in_take) takes++;
            if (out_valid && out_ready) begin
                g_addr[g_n] = out_addr; g_strb[g_n] = out_strb; g_data[g_n] = out_data;
                g_last[g_n] = out_last; g_id[g_n] = out_id;
                g_n++;
            end
            @(negedge clk);
            cyc++;
        end
        out_ready = 1'b0;
        #1;
        check_eq("R8 beat count", 128'(g_n), 128'(n));
        check_eq("R8 no beat after last", 128'(out_valid), 128'(0));
    endtask

    task automatic t_reset();
        check_eq("R1 out_valid", 128'(out_valid), 128'(0));
        check_eq("R1 desc_ready", 128'(desc_ready), 128'(1));
        check_eq("R1 desc_err", 128'(desc_err), 128'(0));
    endtask

    task automatic t_fixed();
        for (int k = 0; k < 5; k++) vals[k] = 32'hA5A5_5A00 | 32'(8'h07 + 8'(k * 14));
        send(4'h3, 32'h0000_0106, 4'd4, 3'd0, 2'd0);
        collect(5, 1'b0);
        for (int k = 0; k < 5; k++) begin
            check_eq("R2 fixed addr", 128'(g_addr[k]), 128'h100);
            check_eq("R3 fixed strb", 128'(g_strb[k]), 128'h0040);
            check_eq("R4 fixed data lane 6", g_data[k], 128'(vals[k][7:0]) << 48);
            check_eq("R8 last flag", 128'(g_last[k]), 128'(k == 4));
            check_eq("R8 id", 128'(g_id[k]), 128'h3);
        end
    endtask

    task automatic t_incr_stall();
        logic [ADDR_W-1:0] ea [4] = '{32'h100, 32'h100, 32'h100, 32'h110};
        logic [BUS_B-1:0]  es [4] = '{16'h00F0, 16'h0F00, 16'hF000, 16'h000F};
        int sh [4] = '{32, 64, 96, 0};
        vals[0] = 32'h4739; vals[1] = 32'h7163; vals[2] = 32'hA395; vals[3] = 32'h1507;
        send(4'h5, 32'h0000_0104, 4'd3, 3'd2, 2'd1);
        collect(4, 1'b1);
        check_eq("R9 in_take count", 128'(takes), 128'(4));
        for (int k = 0; k < 4; k++) begin
            check_eq("R5 incr addr", 128'(g_addr[k]), 128'(ea[k]));
            check_eq("R5 incr strb", 128'(g_strb[k]), 128'(es[k]));
            check_eq("R4 incr data", g_data[k], 128'(vals[k]) << sh[k]);
            check_eq("R8 last flag", 128'(g_last[k]), 128'(k == 3));
        end
    endtask

    task automatic t_wrap4();
        logic [BUS_B-1:0] es [4] = '{16'h00F0, 16'h0F00, 16'hF000, 16'h000F};
        vals[0] = 32'h2211; vals[1] = 32'h7766; vals[2] = 32'h5432; vals[3] = 32'h7123;
        send(4'h9, 32'h0000_0704, 4'd3, 3'd2, 2'd2);
        collect(4, 1'b0);
        for (int k = 0; k < 4; k++) begin
            check_eq("R7 wrap4 addr", 128'(g_addr[k]), 128'h700);
            check_eq("R7 wrap4 strb", 128'(g_strb[k]), 128'(es[k]));
        end
    endtask

    task automatic t_wrap8_bytes();
        for (int k = 0; k < 8; k++) vals[k] = 32'hCCDD_EE00 | 32'(k + 1);
        send(4'hA, 32'h0000_0105, 4'd7, 3'd0, 2'd2);
        collect(8, 1'b0);
        for (int k = 0; k < 8; k++) begin
            int lane = (5 + k) % 8;
            check_eq("R7 wrap8 addr", 128'(g_addr[k]), 128'h100);
            check_eq("R7 wrap8 strb", 128'(g_strb[k]), 128'(1) << lane);
            check_eq("R4 byte data masked", g_data[k], 128'(k + 1) << (lane * 8));
        end
    endtask

    task automatic t_incr_unaligned();
        vals[0] = 32'h4433_2211; vals[1] = 32'h8877_6655;
        send(4'h1, 32'h0000_0103, 4'd1, 3'd2, 2'd1);
        collect(2, 1'b0);
        check_eq("R6 first strb partial", 128'(g_strb[0]), 128'h0008);
        check_eq("R6 second strb aligned", 128'(g_strb[1]), 128'h00F0);
        check_eq("R6 first addr", 128'(g_addr[0]), 128'h100);
        check_eq("R4 first data", g_data[0], 128'h4433_2211);
        check_eq("R4 second data", g_data[1], 128'h8877_6655 << 32);
    endtask

    task automatic t_reject(input string tag, input logic [ADDR_W-1:0] addr,
                            input logic [3:0] len, input logic [2:0] size, input logic [1:0] kind);
        send(4'h2, addr, len, size, kind);
        #1;
        check_eq({"R10 err pulse ", tag}, 128'(desc_err), 128'(1));
        check_eq({"R10 no beat ", tag}, 128'(out_valid), 128'(0));
        @(negedge clk);
        #1;
        check_eq({"R10 err one cycle ", tag}, 128'(desc_err), 128'(0));
        check_eq({"R10 still idle ", tag}, 128'({out_valid, desc_ready}), 128'(2'b01));
    endtask

    task automatic t_busy_ignore();
        vals[0] = 32'h0A0B_0C0D; vals[1] = 32'h1111_2222;
        send(4'h6, 32'h0000_0200, 4'd1, 3'd2, 2'd1);
        desc_id = 4'hF; desc_addr = 32'h0000_0300; desc_len = 4'd3; desc_burst = 2'd0;
        desc_valid = 1'b1;
        #1;
        check_eq("R11 desc_ready low while busy", 128'(desc_ready), 128'(0));
        @(negedge clk);
        desc_valid = 1'b0;
        collect(2, 1'b0);
        check_eq("R11 first beat addr", 128'(g_addr[0]), 128'h200);
        check_eq("R11 second strb", 128'(g_strb[1]), 128'h00F0);
        check_eq("R11 id kept", 128'(g_id[1]), 128'h6);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            #1;
            check_eq("R11 offered descriptor ignored", 128'(out_valid), 128'(0));
        end
    endtask

    initial begin
        #(8 * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_fixed();
        t_incr_stall();
        t_wrap4();
        t_wrap8_bytes();
        t_incr_unaligned();
        t_reject("size", 32'h100, 4'd0, 3'd3, 2'd1);
        t_reject("burst3", 32'h100, 4'd0, 3'd0, 2'd3);
        t_reject("wraplen", 32'h700, 4'd2, 3'd2, 2'd2);
        t_reject("wrapalign", 32'h706, 4'd3, 3'd2, 2'd2);
        t_busy_ignore();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule